// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block gathers thirty-two interrupt lines, records which of them have fired and which are allowed to interrupt, and tells a processor core which source to serve next. Software reaches the state through a 32-bit register port with word addresses. Enable bits and pending bits each have two write views. One view sets the bits written as one, and the other clears them. Both views read back the live bit vector. Every source also carries a small priority value, stored in the upper bits of its own byte lane inside a bank of priority words.

A rising edge on an interrupt line marks that source pending. On every cycle the block looks at the sources that are both pending and enabled and picks the one with the smallest priority value, breaking ties toward the smallest source number. The choice is registered and presented as a request flag plus a source number. When the core acknowledges, the pending bit of the presented source is cleared and the next winner appears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all enable, pending and priority bits are zero, core_req is 0, core_req_id is 0 and every register read returns zero.
- R2: A write to word address 0x00 (enable-set view) sets each enable bit whose data bit is 1 and leaves bits written 0 unchanged; reading word 0x00 returns the enable vector, bit n for source n.
- R3: A write to word address 0x20 (enable-clear view) clears each enable bit whose data bit is 1 and leaves bits written 0 unchanged; reading word 0x20 also returns the enable vector.
- R4: Word address 0x40 (pending-set view) sets the pending bits written as 1, and word address 0x60 (pending-clear view) clears them; zeros have no effect and both addresses read back the pending vector.
- R5: Word addresses 0xC0 to 0xC7 hold the priorities: source n lives in word 0xC0 + n/4, bits [8*(n%4)+7 : 8*(n%4)+6]; the six lower bits of each byte read as zero and data written to them is discarded.
- R6: Any other word address reads as zero, and a write to it changes no enable, pending or priority bit.
- R7: A 0-to-1 transition of irq_lines[n] between two clock edges sets pending bit n; a line held high does not set the bit again after software has cleared it.
- R8: When a set of a pending bit (line edge) and a clear of the same bit (pending-clear write or acknowledge) fall in one cycle, the bit ends up set.
- R9: A source is eligible when both its enable and pending bits are 1. core_req is 1 exactly when some source is eligible; core_req_id is then the eligible source with the smallest priority value, ties going to the smallest source number, and is 0 when core_req is 0.
- R10: core_req and core_req_id are registered and reflect the enable, pending and priority state produced by the same clock edge, so a state change from a write, an edge or an acknowledge shows on them one cycle after it is sampled.
- R11: core_ack high at a clock edge while core_req is 1 clears the pending bit of the source shown on core_req_id; core_ack while core_req is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational from current state |
| irq_lines | input | NUM_SRC (32) | Interrupt inputs, sampled for rising edges |
| core_ack | input | 1 | Acknowledge of the presented request |
| core_req | output | 1 | A request is presented |
| core_req_id | output | ID_W (5) | Number of the presented source |

## Verification
The bench targets the collisions where one cycle carries both a set and a clear of the same pending bit, from an edge against a clear write and from an edge against an acknowledge; a design that let the clear win would drop an interrupt and the request would vanish. Ties between equal priorities and a winner that changes on every acknowledge are walked through explicitly, since a wrong scan direction or comparison would serve the highest-numbered source or starve a low priority value. Writes full of ones to the unused low bits of the priority bytes and to unmapped words would expose a decoder that aliases or stores those bits, and an acknowledge with no request would, in a design without gating, wipe out source 0's pending bit.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    // Word addresses of the register views (byte offset / 4).
    localparam int unsigned EN_SET_WORD   = 'h00;
    localparam int unsigned EN_CLR_WORD   = 'h20;
    localparam int unsigned PEND_SET_WORD = 'h40;
    localparam int unsigned PEND_CLR_WORD = 'h60;
    localparam int unsigned PRIO_WORD     = 'hC0;

    // Width of one byte lane inside a priority word.
    localparam int unsigned LANE_W = 8;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_EN_SET,
        RGN_EN_CLR,
        RGN_PEND_SET,
        RGN_PEND_CLR,
        RGN_PRIO
    } rgn_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int NUM_PRIO_REGS = 8,
    localparam int PIDX_W       = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              region,
    output logic [PIDX_W-1:0] prio_idx
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset   = addr - ADDR_W'(PRIO_WORD);
        region   = RGN_NONE;
        prio_idx = '0;
        if (addr == ADDR_W'(EN_SET_WORD)) begin
            region = RGN_EN_SET;
        end else if (addr == ADDR_W'(EN_CLR_WORD)) begin
            region = RGN_EN_CLR;
        end else if (addr == ADDR_W'(PEND_SET_WORD)) begin
            region = RGN_PEND_SET;
        end else if (addr == ADDR_W'(PEND_CLR_WORD)) begin
            region = RGN_PEND_CLR;
        end else if (addr >= ADDR_W'(PRIO_WORD) &&
                     offset < ADDR_W'(NUM_PRIO_REGS)) begin
            region   = RGN_PRIO;
            prio_idx = PIDX_W'(offset);
        end
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC       = 32,
    parameter int PRIO_W        = 2,
    parameter int DATA_W        = 32,
    parameter int NUM_PRIO_REGS = 8,
    localparam int PIDX_W       = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1,
    localparam int SRC_PER_REG  = DATA_W / LANE_W,
    localparam int PRIO_BITS    = NUM_SRC * PRIO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_lines,
    input  logic                 wr,
    input  rgn_e                 region,
    input  logic [PIDX_W-1:0]    prio_idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   ack_clr,
    output logic [NUM_SRC-1:0]   en_q,
    output logic [NUM_SRC-1:0]   pend_q,
    output logic [PRIO_BITS-1:0] prio_q,
    output logic [NUM_SRC-1:0]   en_d,
    output logic [NUM_SRC-1:0]   pend_d,
    output logic [PRIO_BITS-1:0] prio_d
);

    typedef struct packed {
        logic [NUM_SRC-1:0]   en;
        logic [NUM_SRC-1:0]   pend;
        logic [PRIO_BITS-1:0] prio;
        logic [NUM_SRC-1:0]   line;
    } state_t;

    state_t st_q, st_d;
    logic [NUM_SRC-1:0] rise_c;
    logic [NUM_SRC-1:0] set_p, clr_p, set_e, clr_e;

    always_comb begin
        st_d   = st_q;
        rise_c = irq_lines & ~st_q.line;
        set_p  = rise_c;
        clr_p  = ack_clr;
        set_e  = '0;
        clr_e  = '0;
        st_d.line = irq_lines;
        if (wr) begin
            unique case (region)
                RGN_EN_SET:   set_e = wdata[NUM_SRC-1:0];
                RGN_EN_CLR:   clr_e = wdata[NUM_SRC-1:0];
                RGN_PEND_SET: set_p = set_p | wdata[NUM_SRC-1:0];
                RGN_PEND_CLR: clr_p = clr_p | wdata[NUM_SRC-1:0];
                RGN_PRIO: begin
                    for (int k = 0; k < SRC_PER_REG; k++) begin
                        if (int'(prio_idx) * SRC_PER_REG + k < NUM_SRC) begin
                            st_d.prio[(int'(prio_idx) * SRC_PER_REG + k) * PRIO_W +: PRIO_W] =
                                wdata[k * LANE_W + LANE_W - 1 -: PRIO_W];
                        end
                    end
                end
                default: ;
            endcase
        end
        st_d.en   = (st_q.en & ~clr_e) | set_e;
        // A set in the same cycle as a clear leaves the bit set.
        st_d.pend = (st_q.pend & ~clr_p) | set_p;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;
    assign prio_q = st_q.prio;
    assign en_d   = st_d.en;
    assign pend_d = st_d.pend;
    assign prio_d = st_d.prio;

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RGN_EN_SET) |=>
            ((en_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RGN_EN_CLR) |=>
            ((en_q & $past(wdata[NUM_SRC-1:0])) == '0));

    // Covers R8 as well: an edge wins against any clear in its cycle.
    assert_edge_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c != '0) |=> ((pend_q & $past(rise_c)) == $past(rise_c)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC  = 32,
    parameter int PRIO_W   = 2,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         elig_d,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_d,
    output logic                       req_q,
    output logic [ID_W-1:0]            req_id_q
);

    typedef struct packed {
        logic            req;
        logic [ID_W-1:0] id;
    } win_t;

    win_t win_q, win_d;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        win_d  = '0;
        best_p = '1;
        // Ascending scan with a strict compare keeps the lowest number on ties.
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_d[i] && (!win_d.req || prio_d[i*PRIO_W +: PRIO_W] < best_p)) begin
                win_d.req = 1'b1;
                win_d.id  = ID_W'(i);
                best_p    = prio_d[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign req_q    = win_q.req;
    assign req_id_q = win_q.id;

    assert_idle_id_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> (req_id_q == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               core_ack,
    output logic               core_req,
    output logic [ID_W-1:0]    core_req_id
);

    localparam int SRC_PER_REG   = DATA_W / LANE_W;
    localparam int NUM_PRIO_REGS = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG;
    localparam int PIDX_W        = (NUM_PRIO_REGS > 1) ? $clog2(NUM_PRIO_REGS) : 1;
    localparam int PRIO_BITS     = NUM_SRC * PRIO_W;

    rgn_e                 region;
    logic [PIDX_W-1:0]    prio_idx;
    logic [NUM_SRC-1:0]   ack_clr;
    logic [NUM_SRC-1:0]   en_q, pend_q, en_d, pend_d;
    logic [PRIO_BITS-1:0] prio_q, prio_d;

    irq_bus_decode #(
        .ADDR_W(ADDR_W), .NUM_PRIO_REGS(NUM_PRIO_REGS)
    ) u_decode (
        .addr(bus_addr), .region(region), .prio_idx(prio_idx)
    );

    // Acknowledge only acts while a request is presented.
    always_comb begin
        ack_clr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            ack_clr[i] = core_ack && core_req && (core_req_id == ID_W'(i));
        end
    end

    irq_state_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
        .NUM_PRIO_REGS(NUM_PRIO_REGS)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr(bus_wr),
        .region(region), .prio_idx(prio_idx), .wdata(bus_wdata),
        .ack_clr(ack_clr), .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q),
        .en_d(en_d), .pend_d(pend_d), .prio_d(prio_d)
    );

    irq_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .elig_d(en_d & pend_d), .prio_d(prio_d),
        .req_q(core_req), .req_id_q(core_req_id)
    );

    // Read mux: both views of a bit vector return the live state.
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RGN_EN_SET, RGN_EN_CLR:     bus_rdata[NUM_SRC-1:0] = en_q;
            RGN_PEND_SET, RGN_PEND_CLR: bus_rdata[NUM_SRC-1:0] = pend_q;
            RGN_PRIO: begin
                for (int k = 0; k < SRC_PER_REG; k++) begin
                    if (int'(prio_idx) * SRC_PER_REG + k < NUM_SRC) begin
                        bus_rdata[k * LANE_W + LANE_W - 1 -: PRIO_W] =
                            prio_q[(int'(prio_idx) * SRC_PER_REG + k) * PRIO_W +: PRIO_W];
                    end
                end
            end
            default: ;
        endcase
    end

    assert_req_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (en_q[core_req_id] && pend_q[core_req_id]));

    assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_req |-> ((en_q & pend_q) == '0));

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && core_req && !irq_lines[core_req_id] &&
         !(bus_wr && region == RGN_PEND_SET)) |=> !pend_q[$past(core_req_id)]);

    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        core_ack = 1'b0;
    logic        core_req;
    logic [4:0]  core_req_id;

    always #4 clk = ~clk;  // 125 MHz

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .core_ack(core_ack), .core_req(core_req), .core_req_id(core_req_id)
    );

    // Reference model state
    logic [31:0] m_en, m_pend, m_line;
    int          m_prio [32];
    logic        m_req;
    int          m_id;
    bit          started = 0;
    int          vectors = 0;
    int          fails = 0;
    string       tag = "R1";
    int          cycles = 0;
    bit          done = 0;

    always @(posedge clk) begin
        logic [31:0] rise, sp, cp, se, ce;
        int a;
        started <= 1;
        if (!rst_n) begin
            m_en = 0; m_pend = 0; m_line = 0; m_req = 0; m_id = 0;
            for (int i = 0; i < 32; i++) m_prio[i] = 0;
        end else begin
            rise = irq_lines & ~m_line;
            m_line = irq_lines;
            sp = rise; cp = 0; se = 0; ce = 0;
            a = int'(bus_addr);
            if (bus_wr) begin
                if (a == 'h00) se = bus_wdata;
                else if (a == 'h20) ce = bus_wdata;
                else if (a == 'h40) sp = sp | bus_wdata;
                else if (a == 'h60) cp = bus_wdata;
                else if (a >= 'hC0 && a <= 'hC7)
                    for (int k = 0; k < 4; k++)
                        m_prio[(a - 'hC0) * 4 + k] = int'(bus_wdata[8*k+6 +: 2]);
            end
            if (core_ack && m_req) cp[m_id] = 1'b1;
            m_en = (m_en & ~ce) | se;
            m_pend = (m_pend & ~cp) | sp;
            m_req = 0; m_id = 0;
            for (int p = 0; p < 4 && !m_req; p++)
                for (int i = 0; i < 32 && !m_req; i++)
                    if (m_en[i] && m_pend[i] && m_prio[i] == p) begin
                        m_req = 1; m_id = i;
                    end
        end
    end

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] v = 0;
        if (a == 'h00 || a == 'h20) v = m_en;
        else if (a == 'h40 || a == 'h60) v = m_pend;
        else if (a >= 'hC0 && a <= 'hC7)
            for (int k = 0; k < 4; k++) v[8*k+6 +: 2] = 2'(m_prio[(a - 'hC0) * 4 + k]);
        return v;
    endfunction

    // Compare on every falling edge, between input changes.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] er;
            er = exp_rd(int'(bus_addr));
            vectors++;
            if (core_req !== m_req || int'(core_req_id) != m_id || bus_rdata !== er) begin
                fails++;
                $display("FAIL %s: req=%0b id=%0d rdata=%h at addr %h, expected req=%0b id=%0d rdata=%h",
                         tag, core_req, core_req_id, bus_rdata, bus_addr, m_req, m_id, er);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, got %0d cycles expected at most 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 8'(a); bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0;
        tick();
    endtask

    task automatic rd(input int a);
        bus_addr = 8'(a); tick();
    endtask

    task automatic ack();
        core_ack = 1; tick(); core_ack = 0; tick();
    endtask

    initial begin
        // R1: reset state across every view
        tag = "R1";
        repeat (3) tick();
        rst_n = 1;
        foreach (bus_addr[i]) ;
        rd('h00); rd('h20); rd('h40); rd('h60);
        for (int a = 'hC0; a < 'hC8; a++) rd(a);

        // R2: set view, zeros no effect
        tag = "R2";
        wr('h00, 32'h0000_00F0); rd('h00);
        wr('h00, 32'h0000_0F00); rd('h00); rd('h20);
        // R3: clear view
        tag = "R3";
        wr('h20, 32'h0000_0030); rd('h20); rd('h00);
        wr('h20, 32'h0000_0000); rd('h20);

        // R5: priority fields, low bits discarded
        tag = "R5";
        wr('hC0, 32'hFFFF_FFFF); rd('hC0);
        wr('hC1, 32'h3F80_40C0); rd('hC1);
        wr('hC7, 32'h8040_C000); rd('hC7);
        wr('hC0, 32'h0000_0000); rd('hC0);

        // R6: unmapped addresses
        tag = "R6";
        wr('h10, 32'hFFFF_FFFF); rd('h10);
        wr('h80, 32'hFFFF_FFFF); rd('h80);
        wr('hC8, 32'hFFFF_FFFF); rd('hC8);
        wr('hBF, 32'hFFFF_FFFF); rd('hBF);
        rd('h00); rd('h40); rd('hC7);

        // R4: pending views
        tag = "R4";
        wr('h20, 32'hFFFF_FFFF);
        wr('h40, 32'h8000_0101); rd('h40); rd('h60);
        wr('h60, 32'h0000_0100); rd('h60);
        wr('h60, 32'hFFFF_FFFF); rd('h40);

        // R7: edge sets pending, held level does not re-set
        tag = "R7";
        irq_lines[3] = 1; tick(); rd('h40);
        wr('h60, 32'h0000_0008); rd('h40);
        tick(); rd('h40);
        irq_lines[3] = 0; tick(); irq_lines[3] = 1; tick(); rd('h40);

        // R8: edge against clear write, and against acknowledge
        tag = "R8";
        wr('h00, 32'h0000_0020);
        irq_lines[5] = 1; bus_addr = 8'h60; bus_wdata = 32'h20; bus_wr = 1; tick(); bus_wr = 0;
        rd('h40);
        irq_lines[5] = 0; tick();
        irq_lines[5] = 1; core_ack = 1; tick(); core_ack = 0; rd('h40);
        wr('h60, 32'hFFFF_FFFF); wr('h20, 32'hFFFF_FFFF);
        irq_lines = '0; tick();

        // R9/R10: priority order, ties, walk via acknowledge (R11)
        tag = "R9";
        wr('hC2, 32'h4000_8000);   // src9 prio2, src11 prio1
        wr('hC4, 32'h0000_0040);   // src16 prio1
        wr('h00, 32'h0001_0E01);
        tag = "R10";
        wr('h40, 32'h0001_0A00);
        tag = "R11";
        ack(); ack(); ack(); ack();
        tag = "R9";
        wr('h40, 32'h0000_0201); wr('hC0, 32'h0000_00C0);
        ack(); ack();
        tag = "R11";
        rd('h40); ack(); ack(); rd('h40);
        wr('h40, 32'h0000_0001); wr('h20, 32'h0000_0001);
        ack(); rd('h40);

        // Mixed random traffic
        tag = "R9/R11 random";
        for (int n = 0; n < 3000; n++) begin
            int s;
            s = $urandom_range(0, 6);
            case (s)
                0: bus_addr = 8'h00;
                1: bus_addr = 8'h20;
                2: bus_addr = 8'h40;
                3: bus_addr = 8'h60;
                4, 5: bus_addr = 8'(8'hC0 + $urandom_range(0, 7));
                default: bus_addr = 8'($urandom_range(0, 255));
            endcase
            bus_wdata = $urandom() & $urandom();
            bus_wr = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 1) == 0) irq_lines[$urandom_range(0, 31)] ^= 1'b1;
            core_ack = ($urandom_range(0, 3) == 0);
            tick();
        end
        bus_wr = 0; core_ack = 0; tick(); tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule